// File: doc/BRIEF.md
# Register-Mapped Serial Port with Single-Byte Buffers

This block is a small asynchronous serial port for a processor bus. Software reaches it through a simple valid/write register port with five 32-bit registers: a data register that feeds a one-byte transmit holding buffer and returns the one-byte receive buffer, a state register, a control register, a write-one-to-clear interrupt register and a bit-period divisor. The line format is fixed at eight data bits, no parity and one stop bit, with no flow control.

The divisor gives the length of one serial bit as a whole number of system clocks. It does not use a sixteen-times oversampling clock. Each direction holds a single byte, and a byte that arrives while its buffer is full is dropped and flagged as an overrun. Four interrupt sources drive three lines: transmit, receive, and a shared overrun line. A fourth line is the OR of those three. The receiver brings the line in through a two-flop synchronizer, confirms the start bit at half a bit period, and samples each bit at the middle of its bit time.

Top module: `sio_port`

## Requirements
- R1: After reset the state (0x04), control (0x08) and interrupt (0x0C) registers read 0, the divisor (0x10) reads 16, `txd` is high and every interrupt output is low.
- R2: Control bits [5:0] read back as written, with bits above 5 reading 0. The divisor register keeps the low 21 bits of the written value.
- R3: A transmitted frame is one low start bit, 8 data bits with the LSB first, and one high stop bit. Each bit lasts exactly divisor clocks. Frames start only while control bit 0 (transmit enable) is set.
- R4: A write to the data register (0x00) while state bit 0 (TX full) is clear stores the byte and sets state bit 0. The bit clears when the byte moves into the shifter. At that moment interrupt bit 0 is set if control bit 2 is set.
- R5: A data write while state bit 0 is set is discarded and sets state bit 2 (TX overrun). It also sets interrupt bit 2 if control bit 4 is set.
- R6: With control bit 1 (receive enable) set, a valid frame on `rxd` places its byte in the data register and sets state bit 1 (RX full). It also sets interrupt bit 1 if control bit 3 is set. Reading the data register returns the byte and clears state bit 1.
- R7: A frame that completes while state bit 1 is set is discarded, leaving the held byte unchanged. It sets state bit 3 (RX overrun), and sets interrupt bit 3 if control bit 5 is set.
- R8: These frames are not received: a frame whose stop bit is low, a low pulse on `rxd` shorter than half a bit, and any frame that arrives while receive enable is clear.
- R9: Writing 1 to a bit of the interrupt register clears that flag, and writing 0 leaves it unchanged. Writing 1 to state bit 2 or bit 3 clears that overrun bit. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq_tx` is interrupt bit 0 AND control bit 2, and `irq_rx` is interrupt bit 1 AND control bit 3. `irq_ovr` is (bit 2 AND control bit 4) OR (bit 3 AND control bit 5). `irq_any` is the OR of the three lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_ovr | output | 1 | Overrun interrupt (either direction) |
| irq_any | output | 1 | OR of the three interrupt lines |

## Verification
The assertions check the following on every cycle:
- a write into a full transmit buffer always leads to the overrun bit, and likewise a completed frame into a full receive buffer;
- the held receive byte survives an overrun;
- a read empties the receive buffer;
- a load into the shifter empties the holding buffer;
- a write-one-to-clear removes the receive flag;
- every transmit bit stays stable for its whole period;
- the receiver's completion strobe lasts one cycle.

Only the bench scenarios can show the rest:
- the frame content and its LSB-first order;
- the effect of the enable bits;
- rejection of a low stop bit and of a short glitch;
- the mapping of each flag onto the interrupt lines.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam logic [4:0] OFS_DATA = 5'h00;
   localparam logic [4:0] OFS_STAT = 5'h04;
   localparam logic [4:0] OFS_CTRL = 5'h08;
   localparam logic [4:0] OFS_INTR = 5'h0C;
   localparam logic [4:0] OFS_BAUD = 5'h10;

   // bit 0 is tx_en; software decodes these positions
   typedef struct packed {
      logic rxo_ie;
      logic txo_ie;
      logic rx_ie;
      logic tx_ie;
      logic rx_en;
      logic tx_en;
   } ctrl_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
   parameter int DIV_W  = 21,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div,
   input  logic              enable,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              take,
   output logic              txd
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int BIT_W   = $clog2(FRAME_W);

   logic               busy;
   logic [FRAME_W-1:0] shreg;
   logic [DIV_W-1:0]   cnt;
   logic [BIT_W-1:0]   nbit;

   assign take = enable && hold_full && !busy;
   assign txd  = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         cnt   <= '0;
         nbit  <= '0;
      end else if (take) begin
         busy  <= 1'b1;
         shreg <= {1'b1, hold_data, 1'b0};
         cnt   <= '0;
         nbit  <= '0;
      end else if (busy) begin
         if (cnt == div - DIV_W'(1)) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            if (nbit == BIT_W'(FRAME_W - 1)) busy <= 1'b0;
            else                              nbit <= nbit + BIT_W'(1);
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end
   end

   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (txd == 1'b0));
   a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |-> $stable(txd));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int DIV_W  = 21,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div,
   input  logic              enable,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data
);
   localparam int BIT_W = $clog2(DATA_W);

   logic             s1, s2, s3;
   rx_state_e        state;
   logic [DIV_W-1:0] cnt;
   logic [BIT_W-1:0] nbit;
   logic [DIV_W-1:0] half_m1;
   logic [DIV_W-1:0] full_m1;

   assign half_m1 = (div >> 1) - DIV_W'(1);
   assign full_m1 = div - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
         s3 <= 1'b1;
      end else begin
         s1 <= rxd;
         s2 <= s1;
         s3 <= s2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cnt   <= '0;
         nbit  <= '0;
         data  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            state <= RX_IDLE;
         end else begin
            unique case (state)
               RX_IDLE: if (s3 && !s2) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
               RX_START: if (cnt == half_m1) begin
                  cnt   <= '0;
                  nbit  <= '0;
                  state <= s2 ? RX_IDLE : RX_DATA;
               end else cnt <= cnt + DIV_W'(1);
               RX_DATA: if (cnt == full_m1) begin
                  cnt  <= '0;
                  data <= {s2, data[DATA_W-1:1]};
                  if (nbit == BIT_W'(DATA_W - 1)) state <= RX_STOP;
                  else                            nbit  <= nbit + BIT_W'(1);
               end else cnt <= cnt + DIV_W'(1);
               RX_STOP: if (cnt == full_m1) begin
                  state <= RX_IDLE;
                  done  <= s2;
               end else cnt <= cnt + DIV_W'(1);
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/sio_port.sv
module sio_port
   import sio_pkg::*;
#(
   parameter int DIV_W       = 21,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int DIV_RST     = 16,
   parameter int MIN_DIV     = 16,
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_ovr,
   output logic              irq_any
);
   localparam int CTRL_W = $bits(ctrl_t);

   initial begin : p_param_chk
      if (DIV_W < 5 || DIV_W > 32) $error("sio_port: DIV_W out of range");
      if (DATA_W < 2 || DATA_W > 31) $error("sio_port: DATA_W out of range");
      if (ADDR_W < 5) $error("sio_port: ADDR_W too small");
      if (DIV_RST < MIN_DIV) $error("sio_port: reset divisor below minimum");
   end

   ctrl_t             ctrl;
   logic [DIV_W-1:0]  div_q;
   logic              tx_full, rx_full;
   logic [DATA_W-1:0] tx_buf, rx_buf, rx_byte;
   logic              st_txo, st_rxo;
   logic              fl_tx, fl_rx, fl_txo, fl_rxo;
   logic              take, rx_done;

   logic hit_data, hit_stat, hit_ctrl, hit_intr, hit_baud;
   logic wr_data, wr_stat, wr_ctrl, wr_intr, wr_baud, rd_data;
   logic tx_ovr_ev, rx_ovr_ev, rx_accept;

   assign hit_data = reg_addr == ADDR_W'(OFS_DATA);
   assign hit_stat = reg_addr == ADDR_W'(OFS_STAT);
   assign hit_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
   assign hit_intr = reg_addr == ADDR_W'(OFS_INTR);
   assign hit_baud = reg_addr == ADDR_W'(OFS_BAUD);

   assign wr_data = reg_valid && reg_write && hit_data;
   assign wr_stat = reg_valid && reg_write && hit_stat;
   assign wr_ctrl = reg_valid && reg_write && hit_ctrl;
   assign wr_intr = reg_valid && reg_write && hit_intr;
   assign wr_baud = reg_valid && reg_write && hit_baud;
   assign rd_data = reg_valid && !reg_write && hit_data;

   assign tx_ovr_ev = wr_data && tx_full;
   assign rx_ovr_ev = rx_done && rx_full && !rd_data;
   assign rx_accept = rx_done && !rx_ovr_ev;

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^reg_wdata[31:DIV_W];

   sio_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
      .clk, .rst_n, .div(div_q), .enable(ctrl.tx_en),
      .hold_full(tx_full), .hold_data(tx_buf), .take, .txd
   );

   sio_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
      .clk, .rst_n, .div(div_q), .enable(ctrl.rx_en),
      .rxd, .done(rx_done), .data(rx_byte)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         div_q <= DIV_W'(DIV_RST);
      end else begin
         if (wr_ctrl) ctrl  <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (wr_baud) div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   // holding buffers and overrun state; a set beats a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_full <= 1'b0;
         tx_buf  <= '0;
         rx_full <= 1'b0;
         rx_buf  <= '0;
         st_txo  <= 1'b0;
         st_rxo  <= 1'b0;
      end else begin
         if (take) tx_full <= 1'b0;
         if (wr_data && !tx_full) begin
            tx_full <= 1'b1;
            tx_buf  <= reg_wdata[DATA_W-1:0];
         end
         if (rd_data) rx_full <= 1'b0;
         if (rx_accept) begin
            rx_full <= 1'b1;
            rx_buf  <= rx_byte;
         end
         if (wr_stat && reg_wdata[2]) st_txo <= 1'b0;
         if (wr_stat && reg_wdata[3]) st_rxo <= 1'b0;
         if (tx_ovr_ev) st_txo <= 1'b1;
         if (rx_ovr_ev) st_rxo <= 1'b1;
      end
   end

   // interrupt flags, write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_tx  <= 1'b0;
         fl_rx  <= 1'b0;
         fl_txo <= 1'b0;
         fl_rxo <= 1'b0;
      end else begin
         if (wr_intr && reg_wdata[0]) fl_tx  <= 1'b0;
         if (wr_intr && reg_wdata[1]) fl_rx  <= 1'b0;
         if (wr_intr && reg_wdata[2]) fl_txo <= 1'b0;
         if (wr_intr && reg_wdata[3]) fl_rxo <= 1'b0;
         if (take && ctrl.tx_ie)          fl_tx  <= 1'b1;
         if (rx_accept && ctrl.rx_ie)     fl_rx  <= 1'b1;
         if (tx_ovr_ev && ctrl.txo_ie)    fl_txo <= 1'b1;
         if (rx_ovr_ev && ctrl.rxo_ie)    fl_rxo <= 1'b1;
      end
   end

   logic pend_tx, pend_rx, pend_ovr;
   assign pend_tx  = fl_tx & ctrl.tx_ie;
   assign pend_rx  = fl_rx & ctrl.rx_ie;
   assign pend_ovr = (fl_txo & ctrl.txo_ie) | (fl_rxo & ctrl.rxo_ie);

   generate
      if (IRQ_OUT_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_tx  <= 1'b0;
               irq_rx  <= 1'b0;
               irq_ovr <= 1'b0;
               irq_any <= 1'b0;
            end else begin
               irq_tx  <= pend_tx;
               irq_rx  <= pend_rx;
               irq_ovr <= pend_ovr;
               irq_any <= pend_tx | pend_rx | pend_ovr;
            end
         end
      end else begin : g_irq_comb
         assign irq_tx  = pend_tx;
         assign irq_rx  = pend_rx;
         assign irq_ovr = pend_ovr;
         assign irq_any = pend_tx | pend_rx | pend_ovr;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (hit_data)      reg_rdata = 32'(rx_buf);
      else if (hit_stat) reg_rdata = {28'd0, st_rxo, st_txo, rx_full, tx_full};
      else if (hit_ctrl) reg_rdata = 32'(ctrl);
      else if (hit_intr) reg_rdata = {28'd0, fl_rxo, fl_txo, fl_rx, fl_tx};
      else if (hit_baud) reg_rdata = 32'(div_q);
   end

   a_r5_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_full) |=> st_txo);
   a_r7_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full && !rd_data) |=> st_rxo);
   a_r7_keep_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full && !rd_data) |=> (rx_buf == $past(rx_buf)));
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !rx_full);
   a_r4_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !tx_full);
   a_r9_w1c_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_intr && reg_wdata[1] && !(rx_accept && ctrl.rx_ie)) |=> !fl_rx);
endmodule

// File: tb/sio_port_tb.sv
`timescale 1ns/1ps
module sio_port_tb;
   localparam int DIV = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rxd = 1'b1;
   logic        txd, irq_tx, irq_rx, irq_ovr, irq_any;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sio_port u_dut (
      .clk, .rst_n, .reg_valid, .reg_write, .reg_addr, .reg_wdata, .reg_rdata,
      .rxd, .txd, .irq_tx, .irq_rx, .irq_ovr, .irq_any
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      @(negedge clk);
      rxd = 1'b0;
      repeat (DIV) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (DIV) @(negedge clk);
      end
      rxd = stop;
      repeat (DIV) @(negedge clk);
      rxd = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // called at the first negedge of the start bit
   task automatic sample_frame(output logic [7:0] b, output logic st, output logic sb);
      repeat (DIV/2) @(negedge clk);
      st = txd;
      for (int i = 0; i < 8; i++) begin
         repeat (DIV) @(negedge clk);
         b[i] = txd;
      end
      repeat (DIV) @(negedge clk);
      sb = txd;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(5'h04, v); check("R1 state", v, 0);
      rd(5'h08, v); check("R1 ctrl", v, 0);
      rd(5'h0C, v); check("R1 intr", v, 0);
      rd(5'h10, v); check("R1 divisor", v, 16);
      check("R1 txd", 32'(txd), 1);
      check("R1 irq", {irq_tx, irq_rx, irq_ovr, irq_any}, 0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(5'h08, 32'h3F); rd(5'h08, v); check("R2 ctrl all", v, 32'h3F);
      wr(5'h08, 32'hFFC0); rd(5'h08, v); check("R2 ctrl upper", v, 0);
      wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); check("R2 divisor mask", v, 32'h1F_FFFF);
      wr(5'h10, DIV); rd(5'h10, v); check("R2 divisor", v, DIV);
   endtask

   task automatic t_tx_basic;
      logic [31:0] v;
      logic [7:0] b;
      logic st, sb;
      bit seen = 1'b0;
      wr(5'h0C, 32'hF);
      wr(5'h00, 32'hA5);
      repeat (40) @(negedge clk);
      rd(5'h04, v); check("R3 held while disabled", v, 32'h1);
      check("R3 idle txd while disabled", 32'(txd), 1);
      wr(5'h08, 32'h05);
      for (int i = 0; i < 50 && !seen; i++) begin
         @(negedge clk);
         if (txd == 1'b0) seen = 1'b1;
      end
      check("R3 start seen", 32'(seen), 1);
      sample_frame(b, st, sb);
      check("R3 start bit", 32'(st), 0);
      check("R3 data LSB first", 32'(b), 32'hA5);
      check("R3 stop bit", 32'(sb), 1);
      rd(5'h04, v); check("R4 full cleared", v, 0);
      rd(5'h0C, v); check("R4 tx flag", v, 32'h1);
      check("R10 irq_tx", {irq_tx, irq_rx, irq_ovr, irq_any}, 4'b1001);
      repeat (20) @(negedge clk);
   endtask

   task automatic t_tx_overrun;
      logic [31:0] v;
      logic [7:0] b;
      logic st, sb;
      bit seen = 1'b0;
      wr(5'h0C, 32'hF);
      wr(5'h08, 32'h15);
      wr(5'h00, 32'h11);
      wr(5'h00, 32'h22);
      wr(5'h00, 32'h33);
      rd(5'h04, v); check("R5 state overrun", v, 32'h5);
      rd(5'h0C, v); check("R5 intr overrun", v, 32'h5);
      check("R10 irq_ovr", 32'(irq_ovr), 1);
      wr(5'h04, 32'h4); rd(5'h04, v); check("R9 state w1c", v, 32'h1);
      wr(5'h0C, 32'h5);
      check("R9 intr w1c lines", {irq_tx, irq_ovr, irq_any}, 0);
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk);
         if (irq_tx) seen = 1'b1;
      end
      check("R4 second take", 32'(seen), 1);
      sample_frame(b, st, sb);
      check("R5 kept byte sent", 32'(b), 32'h22);
      repeat (20) @(negedge clk);
      wr(5'h0C, 32'hF);
   endtask

   task automatic t_rx;
      logic [31:0] v;
      wr(5'h08, 32'h2A);
      send_frame(8'h3C, 1'b1);
      rd(5'h04, v); check("R6 rx full", v, 32'h2);
      check("R10 irq_rx", {irq_tx, irq_rx, irq_ovr, irq_any}, 4'b0101);
      wr(5'h0C, 32'h0); rd(5'h0C, v); check("R9 write zero keeps", v, 32'h2);
      rd(5'h00, v); check("R6 data", v, 32'h3C);
      rd(5'h04, v); check("R6 read clears", v, 0);
      wr(5'h0C, 32'h2); check("R9 rx w1c", 32'(irq_rx), 0);
   endtask

   task automatic t_rx_overrun;
      logic [31:0] v;
      send_frame(8'h55, 1'b1);
      send_frame(8'h66, 1'b1);
      rd(5'h04, v); check("R7 state", v, 32'hA);
      rd(5'h0C, v); check("R7 intr", v, 32'hA);
      check("R10 irq_ovr rx", 32'(irq_ovr), 1);
      rd(5'h00, v); check("R7 held byte", v, 32'h55);
      wr(5'h04, 32'h8); rd(5'h04, v); check("R9 rx overrun clear", v, 0);
      wr(5'h0C, 32'hF);
      check("R10 all low", 32'(irq_any), 0);
   endtask

   task automatic t_rx_reject;
      logic [31:0] v;
      send_frame(8'h77, 1'b0);
      repeat (DIV) @(negedge clk);
      rd(5'h04, v); check("R8 bad stop dropped", v, 0);
      @(negedge clk); rxd = 1'b0;
      repeat (3) @(negedge clk); rxd = 1'b1;
      repeat (3*DIV) @(negedge clk);
      rd(5'h04, v); check("R8 glitch ignored", v, 0);
      wr(5'h08, 32'h00);
      send_frame(8'h12, 1'b1);
      rd(5'h04, v); check("R8 disabled ignored", v, 0);
      check("R8 no irq", 32'(irq_any), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_regs();
      t_tx_basic();
      t_tx_overrun();
      t_rx();
      t_rx_overrun();
      t_rx_reject();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule